// File: doc/BRIEF.md
# Windowed Layer Alpha Blender

This block takes one layer's pixel stream and merges it over the colour beneath it. Each beat carries one raw layer word and the screen column and row counters for that pixel. It also carries the 24-bit colour produced by the stage underneath, or the background colour. The block checks whether the position lies inside the layer's rectangular window. It then unpacks the raw word from one of eight programmed formats into 8-bit alpha, red, green and blue. Finally it mixes that colour with the colour beneath, using two selectable weights built from a programmable constant alpha and the pixel's own alpha.

The window limits are given in counter coordinates, so software adds the back-porch offset plus one to the visible column or row. The configuration pins are plain levels that are sampled on the beat that is accepted. The data path is a valid/ready stream with one output register. A beat moves on every edge where both valid and ready are high. While `out_valid` is high and `out_ready` is low, the output beat is held and `in_ready` is low, so back-pressure reaches the source in the same cycle. Layout of `in_under` and `out_rgb`: red in bits 23:16, green in bits 15:8, blue in bits 7:0.

Top module: `layer_window_blend`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A beat accepted at one clock edge appears on `out_valid`/`out_rgb` after that edge. A stalled output (`out_valid` high, `out_ready` low) keeps its value until it is taken. Beats leave in the order they were accepted.
- R2: While reset is active and after it is released, `out_valid` is low and `in_ready` is high until a beat is accepted.
- R3: A pixel is inside the window when `cfg_hwin[11:0] <= in_col <= cfg_hwin[27:16]` and `cfg_vwin[10:0] <= in_row <= cfg_vwin[26:16]`, with both limits inclusive. Outside the window the output equals `in_under`.
- R4: When `cfg_enable` is low, the output equals `in_under` whatever the layer word and window are.
- R5: Format code 0 reads alpha, red, green and blue from bits 31:24, 23:16, 15:8 and 7:0. Code 1 reads red, green and blue from bits 23:0 with alpha 255.
- R6: Code 2 is 5-6-5 in bits 15:0 with alpha 255. Code 3 is a 1-bit alpha in bit 15 (0 gives 0, 1 gives 255) then 5-5-5. Code 4 is 4-4-4-4 with alpha in bits 15:12. Each narrow field widens to 8 bits by repeating its top bits below itself.
- R7: The indexed codes show the index as a grey level on all three channels. Code 5 uses the index in bits 7:0 with alpha 255. Code 6 has alpha in bits 7:4 and the index in bits 3:0, both widened by repetition. Code 7 has alpha in bits 15:8 and the index in bits 7:0.
- R8: Weight W1 is selected by `cfg_blend[10:8]`: code 4 gives the constant alpha A, and any other code (nominally 6) gives P = round(pixel alpha × A / 255). Weight W2 is selected by `cfg_blend[2:0]`: code 5 gives 255 − A, and any other code (nominally 7) gives 255 − P.
- R9: Each output channel is round((W1·layer + W2·under) / 255), limited to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Layer enable |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_hwin | input | 32 | Column start [11:0], column stop [27:16] |
| cfg_vwin | input | 32 | Row start [10:0], row stop [26:16] |
| cfg_blend | input | 16 | W2 code [2:0], W1 code [10:8] |
| cfg_alpha | input | 8 | Constant alpha, 255 means 1.0 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this edge when high with valid |
| in_pix | input | 32 | Raw layer word |
| in_col | input | 12 | Screen column counter |
| in_row | input | 11 | Screen row counter |
| in_under | input | 24 | Colour beneath the layer |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output |
| out_rgb | output | 24 | Blended colour |

## Verification
The clocked assertions take for granted that reset is applied before the first beat. They also take for granted that configuration pins are known levels on every accepted beat, because the bypass checks compare against the under-colour that was present at acceptance. The immediate checks on opaque blending and on alpha-free formats assume only that the format and blend codes are driven. The stimulus changes configuration only while the stream is drained. It keeps each payload steady while a beat waits for `in_ready`, and it toggles `out_ready` at random so that stalls of several cycles occur.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  localparam int CH_W = 8;
  localparam int CH_MAX = (1 << CH_W) - 1;

  typedef enum logic [2:0] {
    FMT_ARGB32 = 3'd0,
    FMT_RGB24  = 3'd1,
    FMT_R5G6B5 = 3'd2,
    FMT_A1RGB5 = 3'd3,
    FMT_ARGB16 = 3'd4,
    FMT_IDX8   = 3'd5,
    FMT_AIDX44 = 3'd6,
    FMT_AIDX88 = 3'd7
  } pix_fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } argb_t;

  localparam logic [2:0] W1_CONST       = 3'd4;
  localparam logic [2:0] W2_ONE_M_CONST = 3'd5;
endpackage

// File: rtl/lwb_expand.sv
module lwb_expand
  import lwb_pkg::*;
(
  input  logic [2:0]  fmt,
  input  logic [31:0] pix,
  output argb_t       px
);
  always_comb begin
    px = '0;
    unique case (pix_fmt_e'(fmt))
      FMT_ARGB32: px = {pix[31:24], pix[23:16], pix[15:8], pix[7:0]};
      FMT_RGB24:  px = {8'hFF, pix[23:16], pix[15:8], pix[7:0]};
      FMT_R5G6B5: px = {8'hFF, pix[15:11], pix[15:13], pix[10:5], pix[10:9],
                        pix[4:0], pix[4:2]};
      FMT_A1RGB5: px = {{8{pix[15]}}, pix[14:10], pix[14:12], pix[9:5], pix[9:7],
                        pix[4:0], pix[4:2]};
      FMT_ARGB16: px = {pix[15:12], pix[15:12], pix[11:8], pix[11:8],
                        pix[7:4], pix[7:4], pix[3:0], pix[3:0]};
      FMT_IDX8:   px = {8'hFF, pix[7:0], pix[7:0], pix[7:0]};
      FMT_AIDX44: px = {pix[7:4], pix[7:4], {3{pix[3:0], pix[3:0]}}};
      FMT_AIDX88: px = {pix[15:8], pix[7:0], pix[7:0], pix[7:0]};
      default:    px = '0;
    endcase
  end

  always_comb begin
    if (fmt == FMT_RGB24) begin
      assert_rgb24_opaque_R5: assert (px.a == 8'hFF)
        else $error("24-bit format produced non-opaque alpha");
    end
  end
endmodule

// File: rtl/lwb_window.sv
module lwb_window #(
  parameter int COL_W = 12,
  parameter int ROW_W = 11
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col_lo,
  input  logic [COL_W-1:0] col_hi,
  input  logic [ROW_W-1:0] row_lo,
  input  logic [ROW_W-1:0] row_hi,
  output logic             hit
);
  logic in_cols, in_rows;
  assign in_cols = (col >= col_lo) && (col <= col_hi);
  assign in_rows = (row >= row_lo) && (row <= row_hi);
  assign hit     = in_cols && in_rows;
endmodule

// File: rtl/lwb_mix.sv
module lwb_mix
  import lwb_pkg::*;
#(
  parameter int NCH = 3
) (
  input  argb_t                layer,
  input  logic [NCH*CH_W-1:0]  under,
  input  logic [2:0]           w1_code,
  input  logic [2:0]           w2_code,
  input  logic [CH_W-1:0]      const_a,
  output logic [NCH*CH_W-1:0]  mixed
);
  localparam int PROD_W = 2 * CH_W;
  localparam int SUM_W  = PROD_W + 2;

  function automatic logic [CH_W-1:0] div_round(input logic [SUM_W-1:0] num);
    logic [SUM_W-1:0] q;
    q = (num + SUM_W'(CH_MAX / 2)) / SUM_W'(CH_MAX);
    div_round = (q > SUM_W'(CH_MAX)) ? CH_W'(CH_MAX) : q[CH_W-1:0];
  endfunction

  logic [CH_W-1:0]       scaled_a;
  logic [CH_W-1:0]       w1, w2;
  logic [NCH*CH_W-1:0]   layer_rgb;

  assign scaled_a  = div_round(SUM_W'(layer.a) * SUM_W'(const_a));
  assign w1        = (w1_code == W1_CONST) ? const_a : scaled_a;
  assign w2        = CH_W'(CH_MAX) - ((w2_code == W2_ONE_M_CONST) ? const_a : scaled_a);
  assign layer_rgb = {layer.r, layer.g, layer.b};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SUM_W-1:0] acc;
    assign acc = SUM_W'(w1) * SUM_W'(layer_rgb[c*CH_W +: CH_W])
               + SUM_W'(w2) * SUM_W'(under[c*CH_W +: CH_W]);
    assign mixed[c*CH_W +: CH_W] = div_round(acc);
  end

  always_comb begin
    if (w1_code == W1_CONST && w2_code == W2_ONE_M_CONST && const_a == CH_W'(CH_MAX)) begin
      assert_opaque_copy_R8: assert (mixed == layer_rgb)
        else $error("opaque constant weights did not reproduce layer colour");
    end
  end
endmodule

// File: rtl/layer_window_blend.sv
module layer_window_blend
  import lwb_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [2:0]       cfg_fmt,
  input  logic [31:0]      cfg_hwin,
  input  logic [31:0]      cfg_vwin,
  input  logic [15:0]      cfg_blend,
  input  logic [7:0]       cfg_alpha,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_pix,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROW_W-1:0] in_row,
  input  logic [23:0]      in_under,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [23:0]      out_rgb
);
  localparam int HI_LSB = 16;
  localparam int RGB_W  = 3 * CH_W;

  argb_t            layer_px;
  logic             win_hit;
  logic [RGB_W-1:0] mixed_rgb;
  logic [RGB_W-1:0] next_rgb;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_hwin[31:HI_LSB+COL_W], cfg_hwin[HI_LSB-1:COL_W],
                        cfg_vwin[31:HI_LSB+ROW_W], cfg_vwin[HI_LSB-1:ROW_W],
                        cfg_blend[15:11], cfg_blend[7:3]};

  lwb_expand u_expand (
    .fmt (cfg_fmt),
    .pix (in_pix),
    .px  (layer_px)
  );

  lwb_window #(.COL_W(COL_W), .ROW_W(ROW_W)) u_window (
    .col    (in_col),
    .row    (in_row),
    .col_lo (cfg_hwin[COL_W-1:0]),
    .col_hi (cfg_hwin[HI_LSB+COL_W-1:HI_LSB]),
    .row_lo (cfg_vwin[ROW_W-1:0]),
    .row_hi (cfg_vwin[HI_LSB+ROW_W-1:HI_LSB]),
    .hit    (win_hit)
  );

  lwb_mix #(.NCH(3)) u_mix (
    .layer   (layer_px),
    .under   (in_under),
    .w1_code (cfg_blend[10:8]),
    .w2_code (cfg_blend[2:0]),
    .const_a (cfg_alpha),
    .mixed   (mixed_rgb)
  );

  assign next_rgb = (cfg_enable && win_hit) ? mixed_rgb : in_under;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_rgb <= next_rgb;
    end
  end

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  assert_stall_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_disabled_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_enable |=> out_valid && out_rgb == $past(in_under));

  assert_outside_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !win_hit |=> out_rgb == $past(in_under));
endmodule

// File: tb/layer_window_blend_tb_top.sv
module layer_window_blend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [2:0]  cfg_fmt;
  logic [31:0] cfg_hwin, cfg_vwin;
  logic [15:0] cfg_blend;
  logic [7:0]  cfg_alpha;
  logic        in_valid, in_ready;
  logic [31:0] in_pix;
  logic [11:0] in_col;
  logic [10:0] in_row;
  logic [23:0] in_under;
  logic        out_valid, out_ready;
  logic [23:0] out_rgb;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string tag;
  logic [23:0] expq[$];
  logic acc_prev;
  int col_base, col_span, row_base, row_span;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_window_blend dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_fmt(cfg_fmt),
    .cfg_hwin(cfg_hwin), .cfg_vwin(cfg_vwin), .cfg_blend(cfg_blend),
    .cfg_alpha(cfg_alpha), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_col(in_col), .in_row(in_row), .in_under(in_under),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnd(input int v, input int div);
    return (v * 255 + div / 2) / div;
  endfunction

  function automatic logic [23:0] model(input logic [31:0] p, input logic [11:0] c,
                                        input logic [10:0] r, input logic [23:0] u);
    int a, cr, cg, cb, pa, f1, f2, res[3], lay[3], und[3];
    if (!cfg_enable || c < cfg_hwin[11:0] || c > cfg_hwin[27:16] ||
        r < cfg_vwin[10:0] || r > cfg_vwin[26:16]) return u;
    case (cfg_fmt)
      3'd0: begin a = p[31:24]; cr = p[23:16]; cg = p[15:8]; cb = p[7:0]; end
      3'd1: begin a = 255; cr = p[23:16]; cg = p[15:8]; cb = p[7:0]; end
      3'd2: begin a = 255; cr = (p[15:11] << 3) | (p[15:11] >> 2);
                  cg = (p[10:5] << 2) | (p[10:5] >> 4); cb = (p[4:0] << 3) | (p[4:0] >> 2); end
      3'd3: begin a = p[15] ? 255 : 0; cr = (p[14:10] << 3) | (p[14:10] >> 2);
                  cg = (p[9:5] << 3) | (p[9:5] >> 2); cb = (p[4:0] << 3) | (p[4:0] >> 2); end
      3'd4: begin a = p[15:12] * 17; cr = p[11:8] * 17; cg = p[7:4] * 17; cb = p[3:0] * 17; end
      3'd5: begin a = 255; cr = p[7:0]; cg = cr; cb = cr; end
      3'd6: begin a = p[7:4] * 17; cr = p[3:0] * 17; cg = cr; cb = cr; end
      default: begin a = p[15:8]; cr = p[7:0]; cg = cr; cb = cr; end
    endcase
    pa = (a * cfg_alpha + 127) / 255;
    f1 = (cfg_blend[10:8] == 3'd4) ? int'(cfg_alpha) : pa;
    f2 = 255 - ((cfg_blend[2:0] == 3'd5) ? int'(cfg_alpha) : pa);
    lay = '{cr, cg, cb};
    und = '{int'(u[23:16]), int'(u[15:8]), int'(u[7:0])};
    for (int i = 0; i < 3; i++) begin
      res[i] = (f1 * lay[i] + f2 * und[i] + 127) / 255;
      if (res[i] > 255) res[i] = 255;
    end
    return {res[0][7:0], res[1][7:0], res[2][7:0]};
  endfunction

  task automatic step(input bit drive);
    @(negedge clk);
    out_ready = drive ? ($urandom % 4 != 0) : 1'b1;
    if (!in_valid || acc_prev) begin
      in_valid = drive ? ($urandom % 3 != 0) : 1'b0;
      in_pix   = $urandom;
      in_under = 24'($urandom);
      in_col   = 12'(col_base + int'($urandom % col_span));
      in_row   = 11'(row_base + int'($urandom % row_span));
    end
    #1;
    check("R1", {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
    if (out_valid && expq.size() == 0) check("R1", 32'd1, 32'd0);
    if (out_valid && out_ready && expq.size() > 0) check(tag, {8'd0, out_rgb}, {8'd0, expq.pop_front()});
    acc_prev = in_valid && in_ready;
    if (acc_prev) expq.push_back(model(in_pix, in_col, in_row, in_under));
  endtask

  task automatic drain();
    while (expq.size() > 0 || out_valid) step(1'b0);
  endtask

  task automatic phase(input string t, input bit en, input int fmt, input int w1,
                       input int w2, input int ca, input int n);
    drain();
    tag = t; cfg_enable = en; cfg_fmt = 3'(fmt);
    cfg_blend = {5'd0, 3'(w1), 5'd0, 3'(w2)}; cfg_alpha = 8'(ca);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; acc_prev = 1'b0;
    in_pix = '0; in_under = '0; in_col = '0; in_row = '0;
    cfg_enable = 1'b0; cfg_fmt = '0; cfg_blend = '0; cfg_alpha = '0;
    cfg_hwin = {4'd0, 12'd4095, 4'd0, 12'd0};
    cfg_vwin = {5'd0, 11'd2047, 5'd0, 11'd0};
    col_base = 0; col_span = 4096; row_base = 0; row_span = 2048;
    tag = "R2";
    repeat (3) @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    check("R2", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);

    phase("R4", 1'b0, 0, 6, 7, 255, 60);
    phase("R5", 1'b1, 0, 4, 5, 255, 40);
    phase("R5", 1'b1, 1, 6, 7, 255, 40);
    phase("R6", 1'b1, 2, 4, 5, 255, 40);
    phase("R6", 1'b1, 3, 6, 7, 255, 40);
    phase("R6", 1'b1, 4, 6, 7, 255, 40);
    phase("R7", 1'b1, 5, 4, 5, 255, 40);
    phase("R7", 1'b1, 6, 6, 7, 255, 40);
    phase("R7", 1'b1, 7, 6, 7, 255, 40);
    phase("R8", 1'b1, 0, 6, 7, 200, 40);
    phase("R8", 1'b1, 0, 4, 5, 100, 40);
    phase("R8", 1'b1, 4, 6, 5, 150, 40);
    phase("R9", 1'b1, 0, 4, 7, 180, 60);
    phase("R9", 1'b1, 3, 4, 7, 255, 40);

    drain();
    cfg_hwin = {4'd0, 12'd20, 4'd0, 12'd10};
    cfg_vwin = {5'd0, 11'd8, 5'd0, 11'd5};
    col_base = 9; col_span = 13; row_base = 4; row_span = 6;
    phase("R3", 1'b1, 0, 6, 7, 230, 200);
    phase("R3", 1'b0, 0, 6, 7, 230, 40);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule